// File: doc/BRIEF.md
# 10 Mb/s Transmit Jabber and Collision Monitor

This block sits beside the transmit path of a 10 Mb/s twisted-pair transceiver and supervises it. It watches the transmit enable coming from the MAC. When a frame runs past a jab limit, the block stops passing that enable on to the line driver. It keeps the driver off until transmit enable has been idle for an unjab period without a break. While it holds the driver off, a jabber status output stays high.

The block also drives the MII collision signal. In half duplex, the signal goes high whenever transmit and receive are active together. It also goes high for the whole time the jabber cut-off is in force. When heartbeat is allowed, a short SQE pulse appears on it a fixed delay after each frame that ends normally. In full duplex, or when heartbeat is disabled by its input, no SQE pulse is produced. In full duplex, overlapping transmit and receive never raise the collision signal.

All timing values are parameters counted in bit-clock cycles, with the block clocked at the 10 MHz bit rate. The defaults are 20 ms jab, 250 ms unjab, 1 us SQE delay and a 10-bit SQE pulse. A generate option can remove the heartbeat generator entirely.

Top module: `jabber_sqe_mon`

## Requirements
- R1: While reset is held and right after it is released, `jabber_o` and `col_o` are 0, and `tx_out_en_o` equals `tx_en_i`.
- R2: While `jabber_o` is 0, `tx_out_en_o` equals `tx_en_i` in the same cycle.
- R3: After `JAB_CYC` consecutive clock edges that sample `tx_en_i` high, `jabber_o` is 1 and `tx_out_en_o` is 0. After `JAB_CYC-1` such edges, `jabber_o` is still 0.
- R4: Once `jabber_o` is 1, it stays 1 and `tx_out_en_o` stays 0 for as long as `tx_en_i` remains high, with no upper limit.
- R5: `jabber_o` clears after `UNJAB_CYC` consecutive edges that sample `tx_en_i` low. Any edge that samples `tx_en_i` high during this countdown restarts it from zero.
- R6: With `full_dup_i`=0, `col_o` is 1 in every cycle in which `tx_en_i` and `rx_act_i` are both 1.
- R7: With `full_dup_i`=1, overlapping `tx_en_i` and `rx_act_i` never raise `col_o`.
- R8: `col_o` is 1 in every cycle in which `jabber_o` is 1, in either duplex mode.
- R9: With `full_dup_i`=0 and `hb_dis_i`=0, take a frame that ends while not jabbed, and call the first edge that samples `tx_en_i` low edge 1. Then `col_o` is 1 after edges `SQE_DLY_CYC+1` through `SQE_DLY_CYC+SQE_LEN_CYC`, and 0 just before and just after that window.
- R10: When `full_dup_i`=1 or `hb_dis_i`=1, no SQE pulse is produced. A pending or running pulse is cancelled at the first edge that sees either input set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock (10 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| rx_act_i | input | 1 | Receive activity indication |
| full_dup_i | input | 1 | 1 selects full duplex |
| hb_dis_i | input | 1 | 1 disables the SQE heartbeat |
| tx_out_en_o | output | 1 | Transmit enable passed to the line driver |
| jabber_o | output | 1 | High from cut-off until re-enable |
| col_o | output | 1 | MII collision output |

## Verification
Several behaviours are checked on every cycle. These are collision during half-duplex overlap, collision while jabbed, and no collision in full duplex or with heartbeat off outside jabber. Checker-side run-length counters also confirm that jabber rises only after the jab count and clears only after the unjab count. Other behaviours can only be shown by the bench's scenarios. These are the exact edge on which cut-off and re-enable happen, the restart of the unjab countdown by a single high sample, and the position and width of the SQE pulse.

// File: rtl/jsm_pkg.sv
package jsm_pkg;
   typedef enum logic [1:0] {
      SQE_IDLE  = 2'd0,
      SQE_WAIT  = 2'd1,
      SQE_PULSE = 2'd2
   } sqe_phase_e;

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/jsm_jabber_timer.sv
module jsm_jabber_timer #(
   parameter int JAB_CYC   = 200000,
   parameter int UNJAB_CYC = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   output logic jabbed
);
   localparam int MAXC = (JAB_CYC > UNJAB_CYC) ? JAB_CYC : UNJAB_CYC;
   localparam int CW   = jsm_pkg::cnt_width(MAXC);
   localparam logic [CW-1:0] JAB_LAST   = CW'(JAB_CYC - 1);
   localparam logic [CW-1:0] UNJAB_LAST = CW'(UNJAB_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         jabbed <= 1'b0;
         cnt    <= '0;
      end else if (!jabbed) begin
         if (tx_en) begin
            if (cnt == JAB_LAST) begin
               jabbed <= 1'b1;
               cnt    <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            cnt <= '0;
         end
      end else begin
         if (tx_en) begin
            cnt <= '0;
         end else if (cnt == UNJAB_LAST) begin
            jabbed <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/jsm_sqe_gen.sv
module jsm_sqe_gen #(
   parameter int SQE_DLY_CYC = 10,
   parameter int SQE_LEN_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic jabbed,
   input  logic hb_allow,
   output logic sqe
);
   import jsm_pkg::*;

   localparam int MAXC = (SQE_DLY_CYC > SQE_LEN_CYC) ? SQE_DLY_CYC : SQE_LEN_CYC;
   localparam int CW   = cnt_width(MAXC);
   localparam logic [CW-1:0] DLY_LAST = CW'(SQE_DLY_CYC - 1);
   localparam logic [CW-1:0] LEN_LAST = CW'(SQE_LEN_CYC - 1);

   sqe_phase_e    phase;
   logic [CW-1:0] cnt;
   logic          tx_q;
   logic          frame_end;

   assign frame_end = tx_q & ~tx_en & ~jabbed;
   assign sqe       = (phase == SQE_PULSE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q  <= 1'b0;
         phase <= SQE_IDLE;
         cnt   <= '0;
      end else begin
         tx_q <= tx_en;
         if (!hb_allow) begin
            phase <= SQE_IDLE;
            cnt   <= '0;
         end else if (frame_end) begin
            phase <= SQE_WAIT;
            cnt   <= '0;
         end else begin
            unique case (phase)
               SQE_WAIT: begin
                  if (cnt == DLY_LAST) begin
                     phase <= SQE_PULSE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               SQE_PULSE: begin
                  if (cnt == LEN_LAST) begin
                     phase <= SQE_IDLE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  phase <= SQE_IDLE;
                  cnt   <= '0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/jsm_col_merge.sv
module jsm_col_merge (
   input  logic tx_en,
   input  logic rx_act,
   input  logic full_dup,
   input  logic jabbed,
   input  logic sqe,
   output logic col
);
   logic overlap;

   always_comb begin
      overlap = tx_en & rx_act & ~full_dup;
      col     = overlap | jabbed | sqe;
   end
endmodule

// File: rtl/jabber_sqe_mon.sv
module jabber_sqe_mon #(
   parameter int JAB_CYC     = 200000,
   parameter int UNJAB_CYC   = 2500000,
   parameter int SQE_DLY_CYC = 10,
   parameter int SQE_LEN_CYC = 10,
   parameter bit HB_SUPPORT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en_i,
   input  logic rx_act_i,
   input  logic full_dup_i,
   input  logic hb_dis_i,
   output logic tx_out_en_o,
   output logic jabber_o,
   output logic col_o
);
   if (JAB_CYC < 2) begin : g_bad_jab
      $error("JAB_CYC must be at least 2");
   end
   if (UNJAB_CYC < 2) begin : g_bad_unjab
      $error("UNJAB_CYC must be at least 2");
   end
   if (SQE_DLY_CYC < 1 || SQE_LEN_CYC < 1) begin : g_bad_sqe
      $error("SQE delay and width must be at least 1");
   end

   logic jabbed;
   logic sqe;
   logic hb_allow;

   assign hb_allow = ~full_dup_i & ~hb_dis_i;

   jsm_jabber_timer #(
      .JAB_CYC   (JAB_CYC),
      .UNJAB_CYC (UNJAB_CYC)
   ) u_jab (
      .clk    (clk),
      .rst_n  (rst_n),
      .tx_en  (tx_en_i),
      .jabbed (jabbed)
   );

   if (HB_SUPPORT) begin : g_hb
      jsm_sqe_gen #(
         .SQE_DLY_CYC (SQE_DLY_CYC),
         .SQE_LEN_CYC (SQE_LEN_CYC)
      ) u_sqe (
         .clk      (clk),
         .rst_n    (rst_n),
         .tx_en    (tx_en_i),
         .jabbed   (jabbed),
         .hb_allow (hb_allow),
         .sqe      (sqe)
      );
   end else begin : g_no_hb
      assign sqe = 1'b0;
   end

   jsm_col_merge u_col (
      .tx_en    (tx_en_i),
      .rx_act   (rx_act_i),
      .full_dup (full_dup_i),
      .jabbed   (jabbed),
      .sqe      (sqe),
      .col      (col_o)
   );

   assign jabber_o    = jabbed;
   assign tx_out_en_o = tx_en_i & ~jabbed;
endmodule

// File: rtl/jsm_mon_chk.sv
module jsm_mon_chk #(
   parameter int JAB_CYC   = 200000,
   parameter int UNJAB_CYC = 2500000
) (
   input logic clk,
   input logic rst_n,
   input logic tx_en_i,
   input logic rx_act_i,
   input logic full_dup_i,
   input logic hb_dis_i,
   input logic tx_out_en_o,
   input logic jabber_o,
   input logic col_o
);
   logic [31:0] hi_run;
   logic [31:0] lo_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
      end else begin
         hi_run <= tx_en_i ? ((hi_run == 32'hFFFF_FFFF) ? hi_run : hi_run + 1) : '0;
         lo_run <= tx_en_i ? '0 : ((lo_run == 32'hFFFF_FFFF) ? lo_run : lo_run + 1);
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !jabber_o);

   // R3
   jab_min_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jabber_o) |-> (hi_run >= 32'(JAB_CYC)));

   // R4
   jab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(jabber_o) |-> !$past(tx_en_i));

   // R5
   unjab_min_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(jabber_o) |-> (lo_run >= 32'(UNJAB_CYC)));

   // R6
   half_overlap_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_dup_i && tx_en_i && rx_act_i) |-> col_o);

   // R7
   full_dup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_dup_i && $past(full_dup_i) && !jabber_o) |-> !col_o);

   // R8
   jab_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jabber_o |-> (col_o && !tx_out_en_o));

   // R10
   hb_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_dis_i && $past(hb_dis_i) && !jabber_o && !(tx_en_i && rx_act_i)) |-> !col_o);
endmodule

bind jabber_sqe_mon jsm_mon_chk #(
   .JAB_CYC   (JAB_CYC),
   .UNJAB_CYC (UNJAB_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_en_i     (tx_en_i),
   .rx_act_i    (rx_act_i),
   .full_dup_i  (full_dup_i),
   .hb_dis_i    (hb_dis_i),
   .tx_out_en_o (tx_out_en_o),
   .jabber_o    (jabber_o),
   .col_o       (col_o)
);

// File: tb/jabber_sqe_mon_tb.sv
module jabber_sqe_mon_tb;
   localparam int JAB   = 20;
   localparam int UNJAB = 30;
   localparam int DLY   = 10;
   localparam int LEN   = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0;
   logic rx_act = 1'b0;
   logic full_dup = 1'b0;
   logic hb_dis = 1'b1;
   logic tx_out_en;
   logic jabber;
   logic col;

   int nchk = 0;
   int nfail = 0;

   always #5 clk = ~clk;

   jabber_sqe_mon #(
      .JAB_CYC     (JAB),
      .UNJAB_CYC   (UNJAB),
      .SQE_DLY_CYC (DLY),
      .SQE_LEN_CYC (LEN),
      .HB_SUPPORT  (1'b1)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_en_i     (tx_en),
      .rx_act_i    (rx_act),
      .full_dup_i  (full_dup),
      .hb_dis_i    (hb_dis),
      .tx_out_en_o (tx_out_en),
      .jabber_o    (jabber),
      .col_o       (col)
   );

   // bits: tx_en, rx_act, full_dup, hb_dis, expected col, expected tx_out_en
   localparam logic [5:0] VEC [8] = '{
      6'b0001_00, // R2 idle
      6'b1001_01, // R2 transmit only
      6'b1101_11, // R6 half-duplex overlap
      6'b0101_00, // R6 receive only
      6'b1111_01, // R7 full-duplex overlap
      6'b0111_00, // R7 receive only, full duplex
      6'b1101_11, // R6 overlap again
      6'b1011_01  // R7 transmit only, full duplex
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic got, input logic exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic sqe_run(input logic expect_pulse, input string tag);
      tx_en = 1'b1;
      tick(5);
      check({tag, " no col during frame"}, col, 1'b0);
      tx_en = 1'b0;
      for (int k = 1; k <= DLY + LEN + 2; k++) begin
         tick(1);
         check(tag, col,
               expect_pulse && (k >= DLY + 1) && (k <= DLY + LEN));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      tick(3);
      check("R1 jabber in reset", jabber, 1'b0);
      check("R1 col in reset", col, 1'b0);
      tx_en = 1'b1;
      #2;
      check("R1 tx_out_en follows in reset", tx_out_en, 1'b1);
      tx_en = 1'b0;
      rst_n = 1'b1;
      tick(1);
      check("R1 jabber after release", jabber, 1'b0);
      check("R1 col after release", col, 1'b0);

      foreach (VEC[i]) begin
         {tx_en, rx_act, full_dup, hb_dis} = VEC[i][5:2];
         #2;
         check($sformatf("R2/R6/R7 vec %0d col", i), col, VEC[i][1]);
         check($sformatf("R2 vec %0d tx_out_en", i), tx_out_en, VEC[i][0]);
         tick(1);
      end
      {tx_en, rx_act, full_dup, hb_dis} = 4'b0001;
      tick(DLY + LEN + 4);

      // R9 heartbeat pulse in half duplex
      hb_dis = 1'b0;
      sqe_run(1'b1, "R9 sqe window");
      // R10 suppressed by heartbeat disable and by full duplex
      hb_dis = 1'b1;
      sqe_run(1'b0, "R10 hb_dis");
      hb_dis = 1'b0;
      full_dup = 1'b1;
      sqe_run(1'b0, "R10 full duplex");
      full_dup = 1'b0;
      // R10 cancel a pending pulse
      tx_en = 1'b1;
      tick(3);
      tx_en = 1'b0;
      tick(3);
      hb_dis = 1'b1;
      for (int k = 0; k < DLY + LEN; k++) begin
         tick(1);
         check("R10 cancel pending", col, 1'b0);
      end

      // R3 jabber cut-off
      tx_en = 1'b1;
      tick(JAB - 1);
      check("R3 jabber before limit", jabber, 1'b0);
      check("R3 tx_out_en before limit", tx_out_en, 1'b1);
      tick(1);
      check("R3 jabber at limit", jabber, 1'b1);
      check("R3 tx_out_en cut", tx_out_en, 1'b0);
      check("R8 col while jabbed", col, 1'b1);
      // R4 holds indefinitely
      tick(60);
      check("R4 jabber held", jabber, 1'b1);
      check("R4 tx_out_en held off", tx_out_en, 1'b0);
      full_dup = 1'b1;
      #2;
      check("R8 col while jabbed in full duplex", col, 1'b1);
      full_dup = 1'b0;
      // R5 unjab with restart
      tx_en = 1'b0;
      tick(10);
      check("R5 jabber mid countdown", jabber, 1'b1);
      tx_en = 1'b1;
      tick(1);
      tx_en = 1'b0;
      tick(UNJAB - 1);
      check("R5 jabber one short after restart", jabber, 1'b1);
      tick(1);
      check("R5 jabber cleared", jabber, 1'b0);
      check("R5 col cleared", col, 1'b0);
      tx_en = 1'b1;
      #2;
      check("R2 tx_out_en after re-enable", tx_out_en, 1'b1);
      tx_en = 1'b0;
      tick(2);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule